// File: doc/BRIEF.md
# IO Address Translation Walker

This block turns a device DMA address into a system address. It reads a three-level translation structure held in memory, one entry per level: first a region entry, then a segment entry, then a page entry. It handles one request at a time. On acceptance it captures the address, the function's state code, a translation-enable flag, an inclusive address window and a translation anchor. It then sends at most three 64-bit reads to a memory port whose latency can vary. It returns a single-cycle response with a page-granular translated address, an offset mask and an access permission.

The controller is a five-state machine:

- **WS_IDLE** accepts a request. It moves to **WS_RTE** when the gate passes, and otherwise to **WS_DONE** with no access.
- **WS_RTE** fetches the region entry. It moves to **WS_STE** when the entry's type field is correct, and otherwise to **WS_DONE**.
- **WS_STE** fetches the segment entry. It moves to **WS_PTE** when the entry's type field is correct, and otherwise to **WS_DONE**.
- **WS_PTE** fetches the page entry and always moves to **WS_DONE**.
- **WS_DONE** presents the response for one cycle and returns to **WS_IDLE**.

While a walk is waiting for read data, the state does not change.

The table origin is the anchor with its flag bit (bit 0) cleared. Indices are taken from the address at these positions:

| Level | Bits | Width |
|---|---|---|
| Region | 52:42 | 11 |
| Segment | 41:31 | 11 |
| Page | 19:12 | 8 |

Each entry sits at the table base plus eight times its index. In a region or segment entry, bits 63:12 give the next table base and bits 3:2 hold a type code:

| Entry | Type code |
|---|---|
| Region | 2'b11 |
| Segment | 2'b10 |

Function state codes are:

| Code | Meaning |
|---|---|
| 0 | reserved |
| 1 | standby |
| 2 | disabled |
| 3 | enabled |
| 4 | blocked |

Codes 5 to 7 are unused.

Top module: `io_xlate_walker`

## Requirements
- R1: A walk performs memory reads only when the function state code is 3 (enabled) or 4 (blocked) and req_xlat_en is 1. Any other combination gives a no-access response with zero memory reads.
- R2: An address below req_lo or above req_hi gives a no-access response with zero memory reads. Addresses equal to either bound are translated.
- R3: The table origin used for the first read is req_anchor with bit 0 cleared.
- R4: The first read address is the origin plus 8 times address bits 52:42. The second is the segment base plus 8 times bits 41:31. The third is the page-table base plus 8 times bits 19:12. Every other address bit has no effect on the reads.
- R5: A region entry whose bits 3:2 are not 2'b11 ends the walk with no access after exactly one read. Otherwise its bits 63:12 (low 12 bits cleared) form the segment table base.
- R6: A segment entry whose bits 3:2 are not 2'b10 ends the walk with no access after exactly two reads. Otherwise its bits 63:12 form the page table base.
- R7: A page entry that is all zero, or has bit 10 set, gives no access. Otherwise the permission is read/write (rsp_perm 2'b11) and rsp_addr is the entry with its low 12 bits cleared.
- R8: A read/write response carries rsp_mask 0xfff and rsp_iova equal to the request address. A no-access response (rsp_perm 2'b00) carries rsp_addr 0, rsp_iova 0 and rsp_mask of all ones.
- R9: busy is high from the cycle after acceptance through the response cycle. A req_valid seen while busy is ignored and starts no walk.
- R10: rsp_valid is a single-cycle pulse. It comes one cycle after the last read data is taken, or one cycle after acceptance when the gate fails. The walker is idle in the following cycle.
- R11: mem_req stays high with a stable mem_addr until mem_rvalid returns, and only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_iova | input | 64 | Device address to translate |
| req_fn_state | input | 3 | Function state code |
| req_xlat_en | input | 1 | Translation enabled for the function |
| req_lo | input | 64 | Lowest permitted address |
| req_hi | input | 64 | Highest permitted address |
| req_anchor | input | 64 | Translation anchor, bit 0 is a flag |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Read request, held until data |
| mem_addr | output | 64 | Entry address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry returned by memory |
| rsp_valid | output | 1 | Response pulse |
| rsp_iova | output | 64 | Translated device address, 0 on no access |
| rsp_addr | output | 64 | Page-aligned system address |
| rsp_mask | output | 64 | Offset mask of the result |
| rsp_perm | output | 2 | 2'b11 read/write, 2'b00 no access |

## Verification
A corrupted table base, or a wrong index field, shows on mem_addr at the next read. The bench compares the first read address directly and cross-checks the read count of every walk. A wrong state transition shows within one response as an extra or missing read, or as a response in the wrong cycle. The page sweep covers every page index with non-index address bits toggled and latencies from one to three cycles. Any mask or offset error therefore appears in the translated address of that same walk.

// File: rtl/iowalk_pkg.sv
package iowalk_pkg;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_RTE,
        WS_STE,
        WS_PTE,
        WS_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        LVL_REGION,
        LVL_SEGMENT,
        LVL_PAGE
    } level_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_RW   = 2'b11
    } access_e;

    // function state codes that allow translation
    localparam logic [2:0] FN_ENABLED = 3'd3;
    localparam logic [2:0] FN_BLOCKED = 3'd4;

endpackage

// File: rtl/iowalk_gate.sv
module iowalk_gate
    import iowalk_pkg::*;
#(
    parameter int AW  = 64,
    parameter int FSW = 3
) (
    input  logic [FSW-1:0] fn_state,
    input  logic           xlat_en,
    input  logic [AW-1:0]  iova,
    input  logic [AW-1:0]  lo,
    input  logic [AW-1:0]  hi,
    output logic           pass
);

    logic fn_live;
    logic in_window;

    assign fn_live   = (fn_state == FSW'(FN_ENABLED)) || (fn_state == FSW'(FN_BLOCKED));
    assign in_window = (iova >= lo) && (iova <= hi);
    assign pass      = fn_live && xlat_en && in_window;

endmodule

// File: rtl/iowalk_addr.sv
module iowalk_addr
    import iowalk_pkg::*;
#(
    parameter int AW        = 64,
    parameter int RX_LSB    = 42,
    parameter int SX_LSB    = 31,
    parameter int PX_LSB    = 12,
    parameter int TIDX_W    = 11,
    parameter int PIDX_W    = 8,
    parameter int ESZ_LOG2  = 3
) (
    input  level_e         level,
    input  logic [AW-1:0]  iova,
    input  logic [AW-1:0]  base,
    output logic [AW-1:0]  entry_addr
);

    localparam int NLVL = 3;
    localparam int LSB_TAB [NLVL] = '{RX_LSB, SX_LSB, PX_LSB};
    localparam int WID_TAB [NLVL] = '{TIDX_W, TIDX_W, PIDX_W};

    logic [AW-1:0] idx [NLVL];
    logic [AW-1:0] idx_sel;

    for (genvar g = 0; g < NLVL; g++) begin : g_idx
        localparam logic [AW-1:0] FIELD_MASK = (AW'(1) << WID_TAB[g]) - AW'(1);
        assign idx[g] = (iova >> LSB_TAB[g]) & FIELD_MASK;
    end

    always_comb begin
        unique case (level)
            LVL_REGION:  idx_sel = idx[0];
            LVL_SEGMENT: idx_sel = idx[1];
            default:     idx_sel = idx[2];
        endcase
        entry_addr = base + (idx_sel << ESZ_LOG2);
    end

endmodule

// File: rtl/iowalk_entry.sv
module iowalk_entry
    import iowalk_pkg::*;
#(
    parameter int                AW        = 64,
    parameter int                TYPE_LSB  = 2,
    parameter int                TYPE_W    = 2,
    parameter logic [TYPE_W-1:0] RGN_CODE  = 2'b11,
    parameter logic [TYPE_W-1:0] SEG_CODE  = 2'b10,
    parameter int                INV_BIT   = 10,
    parameter int                PAGE_BITS = 12
) (
    input  level_e         level,
    input  logic [AW-1:0]  entry,
    output logic           type_ok,
    output logic [AW-1:0]  base_out,
    output logic           page_ok
);

    localparam logic [AW-1:0] OFF_MASK = (AW'(1) << PAGE_BITS) - AW'(1);

    logic [TYPE_W-1:0] tfield;

    assign tfield   = entry[TYPE_LSB +: TYPE_W];
    assign base_out = entry & ~OFF_MASK;
    assign page_ok  = (entry != '0) && !entry[INV_BIT];

    always_comb begin
        unique case (level)
            LVL_REGION:  type_ok = (tfield == RGN_CODE);
            LVL_SEGMENT: type_ok = (tfield == SEG_CODE);
            default:     type_ok = 1'b1;
        endcase
    end

endmodule

// File: rtl/io_xlate_walker.sv
module io_xlate_walker
    import iowalk_pkg::*;
#(
    parameter int                AW              = 64,
    parameter int                FSW             = 3,
    parameter int                RX_LSB          = 42,
    parameter int                SX_LSB          = 31,
    parameter int                PX_LSB          = 12,
    parameter int                TIDX_W          = 11,
    parameter int                PIDX_W          = 8,
    parameter int                TYPE_LSB        = 2,
    parameter int                TYPE_W          = 2,
    parameter logic [TYPE_W-1:0] RGN_CODE        = 2'b11,
    parameter logic [TYPE_W-1:0] SEG_CODE        = 2'b10,
    parameter int                INV_BIT         = 10,
    parameter int                PAGE_BITS       = 12,
    parameter int                ANCHOR_FLAG_BIT = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [AW-1:0]  req_iova,
    input  logic [FSW-1:0] req_fn_state,
    input  logic           req_xlat_en,
    input  logic [AW-1:0]  req_lo,
    input  logic [AW-1:0]  req_hi,
    input  logic [AW-1:0]  req_anchor,
    output logic           busy,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    input  logic           mem_rvalid,
    input  logic [AW-1:0]  mem_rdata,
    output logic           rsp_valid,
    output logic [AW-1:0]  rsp_iova,
    output logic [AW-1:0]  rsp_addr,
    output logic [AW-1:0]  rsp_mask,
    output logic [1:0]     rsp_perm
);

    localparam logic [AW-1:0] PAGE_MASK  = (AW'(1) << PAGE_BITS) - AW'(1);
    localparam logic [AW-1:0] ANCHOR_CLR = ~(AW'(1) << ANCHOR_FLAG_BIT);

    walk_state_e   state_q, state_d;
    level_e        level;
    logic [AW-1:0] iova_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] xaddr_q;
    logic          ok_q;
    logic          gate_pass;
    logic          type_ok;
    logic          page_ok;
    logic [AW-1:0] next_base;

    iowalk_gate #(
        .AW  (AW),
        .FSW (FSW)
    ) u_gate (
        .fn_state (req_fn_state),
        .xlat_en  (req_xlat_en),
        .iova     (req_iova),
        .lo       (req_lo),
        .hi       (req_hi),
        .pass     (gate_pass)
    );

    iowalk_addr #(
        .AW       (AW),
        .RX_LSB   (RX_LSB),
        .SX_LSB   (SX_LSB),
        .PX_LSB   (PX_LSB),
        .TIDX_W   (TIDX_W),
        .PIDX_W   (PIDX_W),
        .ESZ_LOG2 (3)
    ) u_addr (
        .level      (level),
        .iova       (iova_q),
        .base       (base_q),
        .entry_addr (mem_addr)
    );

    iowalk_entry #(
        .AW        (AW),
        .TYPE_LSB  (TYPE_LSB),
        .TYPE_W    (TYPE_W),
        .RGN_CODE  (RGN_CODE),
        .SEG_CODE  (SEG_CODE),
        .INV_BIT   (INV_BIT),
        .PAGE_BITS (PAGE_BITS)
    ) u_entry (
        .level    (level),
        .entry    (mem_rdata),
        .type_ok  (type_ok),
        .base_out (next_base),
        .page_ok  (page_ok)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE: if (req_valid)  state_d = gate_pass ? WS_RTE : WS_DONE;
            WS_RTE:  if (mem_rvalid) state_d = type_ok ? WS_STE : WS_DONE;
            WS_STE:  if (mem_rvalid) state_d = type_ok ? WS_PTE : WS_DONE;
            WS_PTE:  if (mem_rvalid) state_d = WS_DONE;
            WS_DONE:                 state_d = WS_IDLE;
            default:                 state_d = WS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    // walk registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iova_q  <= '0;
            base_q  <= '0;
            xaddr_q <= '0;
            ok_q    <= 1'b0;
        end else begin
            unique case (state_q)
                WS_IDLE: begin
                    if (req_valid) begin
                        iova_q  <= req_iova;
                        base_q  <= req_anchor & ANCHOR_CLR;
                        xaddr_q <= '0;
                        ok_q    <= 1'b0;
                    end
                end
                WS_RTE, WS_STE: begin
                    if (mem_rvalid && type_ok) base_q <= next_base;
                end
                WS_PTE: begin
                    if (mem_rvalid) begin
                        ok_q    <= page_ok;
                        xaddr_q <= next_base;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            WS_RTE:  level = LVL_REGION;
            WS_STE:  level = LVL_SEGMENT;
            default: level = LVL_PAGE;
        endcase
        busy      = (state_q != WS_IDLE);
        mem_req   = (state_q == WS_RTE) || (state_q == WS_STE) || (state_q == WS_PTE);
        rsp_valid = (state_q == WS_DONE);
        rsp_perm  = ok_q ? ACC_RW : ACC_NONE;
        rsp_addr  = ok_q ? xaddr_q : '0;
        rsp_iova  = ok_q ? iova_q : '0;
        rsp_mask  = ok_q ? PAGE_MASK : '1;
    end

    // R1
    gate_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_IDLE && req_valid && !gate_pass)
        |=> (rsp_valid && !mem_req && rsp_perm == ACC_NONE));

    // R5
    type_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == WS_RTE || state_q == WS_STE) && mem_rvalid && !type_ok)
        |=> (rsp_valid && rsp_perm == ACC_NONE));

    // R7
    page_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_perm == ACC_RW) |-> (rsp_addr[PAGE_BITS-1:0] == '0));

    // R8
    ok_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_perm == ACC_RW) |-> (rsp_mask == PAGE_MASK));

    // R8
    fault_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_perm == ACC_NONE)
        |-> (rsp_mask == '1 && rsp_addr == '0 && rsp_iova == '0));

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && !busy));

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

endmodule

// File: tb/io_xlate_walker_tb.sv
`timescale 1ns/1ps
module io_xlate_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid;
    logic [63:0] req_iova, req_lo, req_hi, req_anchor;
    logic [2:0]  req_fn_state;
    logic        req_xlat_en;
    logic        busy, mem_req, mem_rvalid, rsp_valid;
    logic [63:0] mem_addr, mem_rdata, rsp_iova, rsp_addr, rsp_mask;
    logic [1:0]  rsp_perm;

    always #5 clk = ~clk;

    io_xlate_walker u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_iova (req_iova), .req_fn_state (req_fn_state),
        .req_xlat_en (req_xlat_en), .req_lo (req_lo), .req_hi (req_hi),
        .req_anchor (req_anchor), .busy (busy),
        .mem_req (mem_req), .mem_addr (mem_addr),
        .mem_rvalid (mem_rvalid), .mem_rdata (mem_rdata),
        .rsp_valid (rsp_valid), .rsp_iova (rsp_iova), .rsp_addr (rsp_addr),
        .rsp_mask (rsp_mask), .rsp_perm (rsp_perm)
    );

    logic [63:0] mem [bit [63:0]];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    int          lat_cfg = 1;
    int          reads_seen = 0;
    int          hold_err = 0;
    logic [63:0] first_rd = '0;
    logic [63:0] srv_addr = '0;

    localparam logic [63:0] ORG = 64'h0000_0000_0010_0000;

    function automatic logic [63:0] memrd(input logic [63:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'd0;
    endfunction

    function automatic logic [63:0] mk(input int rx, input int sx, input int px, input logic [63:0] fill);
        return (64'(rx) << 42) | (64'(sx) << 31) | (64'(px) << 12) | fill;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // independent reference of the walk, from the requirements
    task automatic ref_walk(input logic [2:0] fs, input logic en, input logic [63:0] lo,
                            input logic [63:0] hi, input logic [63:0] anc, input logic [63:0] iv,
                            output logic [1:0] perm, output logic [63:0] addr,
                            output logic [63:0] mask, output logic [63:0] riova,
                            output int nrd, output logic [63:0] a0);
        logic [63:0] e, b;
        perm = 2'b00; addr = '0; mask = '1; riova = '0; nrd = 0; a0 = '0;
        if (!((fs == 3'd3 || fs == 3'd4) && en)) return;
        if (iv < lo || iv > hi) return;
        a0  = (anc & ~64'h1) + ((iv >> 42) & 64'h7ff) * 8;
        e   = memrd(a0); nrd = 1;
        if (((e >> 2) & 64'h3) != 64'h3) return;
        b   = e & ~64'hfff;
        e   = memrd(b + ((iv >> 31) & 64'h7ff) * 8); nrd = 2;
        if (((e >> 2) & 64'h3) != 64'h2) return;
        b   = e & ~64'hfff;
        e   = memrd(b + ((iv >> 12) & 64'hff) * 8); nrd = 3;
        if (e == 64'd0 || e[10]) return;
        perm = 2'b11; addr = e & ~64'hfff; mask = 64'hfff; riova = iv;
    endtask

    // memory model, latency lat_cfg cycles, checks request hold (R11)
    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            if (mem_req === 1'b1) begin
                srv_addr = mem_addr;
                if (reads_seen == 0) first_rd = mem_addr;
                reads_seen++;
                repeat (lat_cfg - 1) begin
                    @(negedge clk);
                    if (mem_req !== 1'b1 || mem_addr !== srv_addr) hold_err++;
                end
                mem_rdata  = memrd(srv_addr);
                mem_rvalid = 1'b1;
                @(negedge clk);
                mem_rvalid = 1'b0;
                mem_rdata  = '0;
            end
        end
    end

    task automatic run(input string tag, input logic [2:0] fs, input logic en,
                       input logic [63:0] lo, input logic [63:0] hi,
                       input logic [63:0] anc, input logic [63:0] iv, input bit poke);
        logic [1:0]  eperm;
        logic [63:0] eaddr, emask, eiova, ea0;
        int          enr;
        int          guard;
        ref_walk(fs, en, lo, hi, anc, iv, eperm, eaddr, emask, eiova, enr, ea0);
        reads_seen = 0;
        @(negedge clk);
        req_valid = 1'b1; req_fn_state = fs; req_xlat_en = en;
        req_lo = lo; req_hi = hi; req_anchor = anc; req_iova = iv;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            // R9: request while busy must be ignored
            req_valid = 1'b1;
            req_iova  = iv ^ 64'h0000_0400_0000_3000;
            @(negedge clk);
            req_valid = 1'b0;
        end
        guard = 0;
        while (rsp_valid !== 1'b1 && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk({tag, " perm"}, 64'(rsp_perm), 64'(eperm));
        chk({tag, " addr"}, rsp_addr, eaddr);
        chk({tag, " R8 mask"}, rsp_mask, emask);
        chk({tag, " R8 iova"}, rsp_iova, eiova);
        chk({tag, " R9 read count"}, 64'(reads_seen), 64'(enr));
        if (enr > 0) chk({tag, " R4 first read addr"}, first_rd, ea0);
        @(negedge clk);
        // R10: single pulse, idle afterwards
        chk({tag, " R10 idle after response"}, {62'd0, rsp_valid, busy}, 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        req_valid = 1'b0; req_iova = '0; req_fn_state = '0; req_xlat_en = 1'b0;
        req_lo = '0; req_hi = '0; req_anchor = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset outputs", {61'd0, busy, mem_req, rsp_valid}, 64'd0);
        rst_n = 1'b1;

        // region table
        mem[ORG + 1 * 8]    = 64'h0000_0000_0020_0000 | (64'h3 << 2) | 64'h1;
        mem[ORG + 2 * 8]    = 64'h0000_0000_0028_0000 | (64'h2 << 2);
        mem[ORG + 2047 * 8] = 64'h0000_0000_0050_0000 | (64'h3 << 2);
        // segment tables
        mem[64'h20_0000 + 4 * 8]    = 64'h0000_0000_0030_0000 | (64'h2 << 2) | 64'h2;
        mem[64'h20_0000 + 5 * 8]    = 64'h0000_0000_0038_0000 | (64'h3 << 2);
        mem[64'h50_0000 + 2047 * 8] = 64'h0000_0000_0060_0000 | (64'h2 << 2);
        // page tables
        for (int p = 0; p < 256; p++) begin
            case (p % 4)
                0: mem[64'h30_0000 + 64'(p) * 8] = 64'h4000_0000 + (64'(p) << 12) | 64'h3;
                1: mem[64'h30_0000 + 64'(p) * 8] = 64'h4000_0000 + (64'(p) << 12) | (64'h1 << 10);
                2: mem[64'h30_0000 + 64'(p) * 8] = 64'h8_0000_0000 + (64'(p) << 12) | 64'h3f0;
                default: ;
            endcase
        end
        mem[64'h60_0000 + 255 * 8] = 64'h0000_0000_7777_7003;

        // R7 R4 R3: all page indices, non-index bits toggled, varied latency
        for (int p = 0; p < 256; p++) begin
            lat_cfg = 1 + (p % 3);
            run("R7 sweep", 3'd3, 1'b1, 64'd0, '1, ORG | 64'h1,
                mk(1, 4, p, ((64'(p * 37) & 64'h7ff) << 20) | (64'(p * 101) & 64'hfff)), p == 9);
        end

        // R1: every state code with enable on and off
        lat_cfg = 2;
        for (int f = 0; f < 8; f++) begin
            for (int e = 0; e < 2; e++) begin
                run("R1 gate", 3'(f), 1'(e), 64'd0, '1, ORG | 64'h1, mk(1, 4, 0, 64'h123), 1'b0);
            end
        end

        // R2: window edges
        run("R2 below", 3'd4, 1'b1, mk(1, 4, 8, 0), mk(1, 4, 16, 64'hfff), ORG, mk(1, 4, 8, 0) - 1, 1'b0);
        run("R2 at lo", 3'd4, 1'b1, mk(1, 4, 8, 0), mk(1, 4, 16, 64'hfff), ORG, mk(1, 4, 8, 0), 1'b0);
        run("R2 at hi", 3'd4, 1'b1, mk(1, 4, 8, 0), mk(1, 4, 16, 64'hfff), ORG, mk(1, 4, 16, 64'hfff), 1'b0);
        run("R2 above", 3'd4, 1'b1, mk(1, 4, 8, 0), mk(1, 4, 16, 64'hfff), ORG, mk(1, 4, 16, 64'hfff) + 1, 1'b0);

        // R3: anchor flag clear or set gives the same origin
        run("R3 anchor clear", 3'd3, 1'b1, 64'd0, '1, ORG, mk(1, 4, 12, 64'h5), 1'b0);

        // R5 R6: type field and empty entries
        lat_cfg = 3;
        run("R5 wrong region type", 3'd3, 1'b1, 64'd0, '1, ORG | 64'h1, mk(2, 4, 0, 0), 1'b0);
        run("R5 empty region", 3'd3, 1'b1, 64'd0, '1, ORG | 64'h1, mk(3, 4, 0, 0), 1'b0);
        run("R6 wrong segment type", 3'd3, 1'b1, 64'd0, '1, ORG | 64'h1, mk(1, 5, 0, 0), 1'b1);
        run("R6 empty segment", 3'd3, 1'b1, 64'd0, '1, ORG | 64'h1, mk(1, 6, 0, 0), 1'b0);
        run("R4 top indices", 3'd3, 1'b1, 64'd0, '1, ORG | 64'h1, mk(2047, 2047, 255, 64'h7ff_0fff & 64'h7ff0_0fff), 1'b0);

        // R11: request held stable while waiting
        chk("R11 hold errors", 64'(hold_err), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule